// File: doc/BRIEF.md
# Segment Register with Descriptor Cache Loader

This block models one segment register of a protected-mode address unit. The register is a visible 16-bit selector paired with a hidden copy of the 8-byte segment descriptor. When software writes a selector, the block splits it into a privilege field, a table-select bit and an entry index. It then forms the address of the entry in either the global or the local descriptor table and reads the entry as two 32-bit words over a request/acknowledge memory port. If the entry has never been used, the block writes the high word back with its used flag set. The decoded base, limit, granularity and access byte are then captured into the hidden copy.

Every later address reference reads only the hidden copy. A linear address and the byte-granular effective limit come straight from the cached fields, with no memory traffic. An edit to a table entry in memory therefore has no effect until the selector is written again. Privilege checking of the loaded entry is done elsewhere.

Top module: `seg_cache_loader`

## Requirements
- R1: After reset `busy`, `cache_valid` and `mem_req` are low, and the selector and all cached fields read zero.
- R2: A selector write accepted while idle appears on `sel_q` from the next cycle. `sel_rpl` shows bits 1:0, `sel_ti` shows bit 2 and `sel_index` shows bits 15:3.
- R3: The entry address is the table base (`gdt_base` when bit 2 is 0, `ldt_base` when it is 1) plus index times 8. Every request is word aligned and is held with a stable address until acknowledged.
- R4: A load makes exactly two reads, the low word at the entry address first and then the high word at the entry address plus 4.
- R5: The used flag is bit 0 of the access byte, which is bit 8 of the high word. If it is clear, exactly one write to the entry address plus 4 follows the reads, carrying the high word with bit 8 set. If it is already set, no write occurs.
- R6: Cached fields decode as follows. Limit bits 15:0 come from low word bits 15:0 and limit bits 19:16 from high word bits 19:16. Base bits 15:0 come from low word bits 31:16 and base bits 23:16 from high word bits 7:0. The access byte is high word bits 15:8 and always has bit 0 set. Granularity is high word bit 23. High word bits 31:24 are dropped.
- R7: `busy` is high from the cycle after an accepted selector write until the load completes. `cache_valid` is low throughout the load and is high in the first cycle that `busy` is low again.
- R8: A selector write made while `busy` is high is ignored. The selector, the memory traffic and the loaded fields all follow the first write.
- R9: While idle the block makes no memory request. `lin_addr` equals cached base plus `ref_off` modulo 2^24. `eff_limit` is the limit when granularity is 0, and limit×4096+4095 when it is 1.
- R10: Changing a table entry in memory leaves every cached field and `lin_addr` unchanged until the selector is written again. The next write loads the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_wdata | input | 16 | Selector value to write |
| gdt_base | input | 32 | Global table base address |
| ldt_base | input | 32 | Local table base address |
| busy | output | 1 | Load in progress |
| cache_valid | output | 1 | Hidden copy holds a complete entry |
| sel_q | output | 16 | Current selector |
| sel_index | output | 13 | Entry index field of the selector |
| sel_ti | output | 1 | Table-select bit of the selector |
| sel_rpl | output | 2 | Requested privilege field of the selector |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed this cycle |
| ref_off | input | 24 | Offset of a segment reference |
| cached_base | output | 24 | Cached base |
| cached_limit | output | 20 | Cached raw limit |
| cached_gran | output | 1 | Cached granularity |
| cached_access | output | 8 | Cached access byte |
| eff_limit | output | 32 | Byte-granular limit |
| lin_addr | output | 24 | Cached base plus `ref_off` |

## Verification
The assertions assume that the memory side raises `mem_ack` only while `mem_req` is high, and for one cycle per request. They also assume that the table bases stay fixed during a load. The bench memory model meets both. It acknowledges a pending request after zero to two idle cycles and drops the acknowledge in the following cycle, and it changes the table bases only between loads. The sweep covers every index of a small table of 16 entries in both tables, with the used flag set and clear. It also tries writes while busy and memory edits made after a load.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEL_W    = 16;
    localparam int RPL_W    = 2;
    localparam int IDX_W    = SEL_W - RPL_W - 1;
    localparam int AW       = 32;
    localparam int DW       = 32;
    localparam int BASE_W   = 24;
    localparam int LIM_W    = 20;
    localparam int ACC_W    = 8;
    localparam int ENTRY_SH = 3;
    localparam int HI_OFS   = DW / 8;
    localparam int USED_POS = 8;
    localparam int PAGE_SH  = 12;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             ti;
        logic [RPL_W-1:0] rpl;
    } sel_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic [ACC_W-1:0]  access;
    } desc_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_RD_LO,
        LD_RD_HI,
        LD_WR_BACK
    } ld_state_e;

    function automatic desc_t unpack_desc(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
        desc_t d;
        d.base   = {hi[7:0], lo[31:16]};
        d.limit  = {hi[19:16], lo[15:0]};
        d.gran   = hi[23];
        d.access = hi[15:8] | ACC_W'(1);
        return d;
    endfunction

    function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] tbl,
                                                 input logic [IDX_W-1:0] idx);
        return tbl + (AW'(idx) << ENTRY_SH);
    endfunction

    function automatic logic [AW-1:0] byte_limit(input desc_t d);
        logic [AW-1:0] r;
        if (d.gran)
            r = {{(AW-LIM_W-PAGE_SH){1'b0}}, d.limit, {PAGE_SH{1'b1}}};
        else
            r = {{(AW-LIM_W){1'b0}}, d.limit};
        return r;
    endfunction

endpackage

// File: rtl/seg_sel_reg.sv
module seg_sel_reg
    import seg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SEL_W-1:0] wdata,
    input  logic [AW-1:0] gdt_base,
    input  logic [AW-1:0] ldt_base,
    output sel_t          sel_q,
    output logic [AW-1:0] desc_addr
);
    sel_t          sel_in;
    logic [AW-1:0] tbl;

    always_comb begin
        sel_in = sel_t'(wdata);
        tbl    = sel_in.ti ? ldt_base : gdt_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            desc_addr <= '0;
        end else if (load) begin
            sel_q     <= sel_in;
            desc_addr <= entry_addr(tbl, sel_in.index);
        end
    end

    // R2: the captured selector reproduces the written value
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (sel_q == $past(wdata)));

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
    import seg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] desc_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          commit,
    output logic [DW-1:0] lo_word,
    output logic [DW-1:0] hi_word
);
    ld_state_e     st;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LD_IDLE;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            case (st)
                LD_IDLE:    if (start) st <= LD_RD_LO;
                LD_RD_LO:   if (mem_ack) begin
                                lo_q <= mem_rdata;
                                st   <= LD_RD_HI;
                            end
                LD_RD_HI:   if (mem_ack) begin
                                hi_q <= mem_rdata;
                                st   <= mem_rdata[USED_POS] ? LD_IDLE : LD_WR_BACK;
                            end
                LD_WR_BACK: if (mem_ack) st <= LD_IDLE;
                default:    st <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != LD_IDLE);
        mem_req   = busy;
        mem_we    = (st == LD_WR_BACK);
        mem_addr  = (st == LD_RD_LO) ? desc_addr : desc_addr + AW'(HI_OFS);
        mem_wdata = hi_q | (DW'(1) << USED_POS);
        commit    = mem_ack && (((st == LD_RD_HI) && mem_rdata[USED_POS]) ||
                                (st == LD_WR_BACK));
        lo_word   = lo_q;
        hi_word   = (st == LD_RD_HI) ? mem_rdata : hi_q;
    end

    // R3: requests are word aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R3: a pending request keeps its address until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R5: the write-back always carries the used flag
    a_r5_wb_flag: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata[USED_POS]);
    // R7: an accepted start raises busy in the next cycle
    a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              commit,
    input  logic [DW-1:0]     lo_word,
    input  logic [DW-1:0]     hi_word,
    input  logic [BASE_W-1:0] ref_off,
    output logic              valid,
    output desc_t             desc_q,
    output logic [AW-1:0]     eff_limit,
    output logic [BASE_W-1:0] lin_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            desc_q <= '0;
        end else begin
            if (commit) begin
                desc_q <= unpack_desc(lo_word, hi_word);
                valid  <= 1'b1;
            end else if (start) begin
                valid  <= 1'b0;
            end
        end
    end

    always_comb begin
        eff_limit = byte_limit(desc_q);
        lin_addr  = desc_q.base + ref_off;
    end

    // R10: cached fields move only on a completed load
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(desc_q));
    // R6: every loaded entry shows the used flag
    a_r6_used_set: assert property (@(posedge clk) disable iff (rst)
        commit |=> (valid && desc_q.access[0]));

endmodule

// File: rtl/seg_cache_loader.sv
module seg_cache_loader
    import seg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_wr,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic [AW-1:0]       gdt_base,
    input  logic [AW-1:0]       ldt_base,
    output logic                busy,
    output logic                cache_valid,
    output logic [SEL_W-1:0]    sel_q,
    output logic [IDX_W-1:0]    sel_index,
    output logic                sel_ti,
    output logic [RPL_W-1:0]    sel_rpl,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                mem_ack,
    input  logic [BASE_W-1:0]   ref_off,
    output logic [BASE_W-1:0]   cached_base,
    output logic [LIM_W-1:0]    cached_limit,
    output logic                cached_gran,
    output logic [ACC_W-1:0]    cached_access,
    output logic [AW-1:0]       eff_limit,
    output logic [BASE_W-1:0]   lin_addr
);
    logic          start;
    logic          commit;
    sel_t          sel_s;
    desc_t         desc_s;
    logic [AW-1:0] desc_addr;
    logic [DW-1:0] lo_w;
    logic [DW-1:0] hi_w;

    assign start = sel_wr && !busy;

    seg_sel_reg u_sel (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .wdata     (sel_wdata),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .sel_q     (sel_s),
        .desc_addr (desc_addr)
    );

    seg_fetch_ctrl u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .desc_addr (desc_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .commit    (commit),
        .lo_word   (lo_w),
        .hi_word   (hi_w)
    );

    seg_desc_cache u_cache (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .commit    (commit),
        .lo_word   (lo_w),
        .hi_word   (hi_w),
        .ref_off   (ref_off),
        .valid     (cache_valid),
        .desc_q    (desc_s),
        .eff_limit (eff_limit),
        .lin_addr  (lin_addr)
    );

    always_comb begin
        sel_q         = sel_s;
        sel_index     = sel_s.index;
        sel_ti        = sel_s.ti;
        sel_rpl       = sel_s.rpl;
        cached_base   = desc_s.base;
        cached_limit  = desc_s.limit;
        cached_gran   = desc_s.gran;
        cached_access = desc_s.access;
    end

    // R7: the hidden copy is never reported valid during a load
    a_r7_busy_invalid: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cache_valid);
    // R8: selector writes during a load leave the selector untouched
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && busy) |=> $stable(sel_q));
    // R9: no memory traffic while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sel_wr) |=> (!mem_req || $past(sel_wr)));

endmodule

// File: tb/sim_seg_cache_loader.sv
module sim_seg_cache_loader;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_wr;
    logic [15:0] sel_wdata;
    logic [31:0] gdt_base;
    logic [31:0] ldt_base;
    logic        busy;
    logic        cache_valid;
    logic [15:0] sel_q;
    logic [12:0] sel_index;
    logic        sel_ti;
    logic [1:0]  sel_rpl;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic [23:0] ref_off;
    logic [23:0] cached_base;
    logic [19:0] cached_limit;
    logic        cached_gran;
    logic [7:0]  cached_access;
    logic [31:0] eff_limit;
    logic [23:0] lin_addr;

    always #10 clk = ~clk;

    seg_cache_loader u0 (.*);

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int lat = 0;
    int lat_cnt = 0;
    int idle_req = 0;
    int log_n = 0;
    logic [31:0] log_addr [0:7];
    logic        log_we   [0:7];
    logic [31:0] mem [0:63];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // memory model: acknowledges after lat idle cycles, drops ack next cycle
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else begin
            if (mem_req && !busy) idle_req++;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (lat_cnt >= lat) begin
                    lat_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                    else mem_rdata = mem[mem_addr[7:2]];
                    if (log_n < 8) begin
                        log_addr[log_n] = mem_addr;
                        log_we[log_n]   = mem_we;
                    end
                    log_n++;
                end else lat_cnt++;
            end
        end
    end

    function automatic logic [23:0] g_base(input int ti, input int idx, input int v);
        return 24'(idx * 24'h011111 + ti * 24'h800000 + v * 24'h000F00);
    endfunction
    function automatic logic [19:0] g_lim(input int ti, input int idx, input int v);
        return 20'(20'h01234 ^ (idx << 12) ^ (v * 20'h00321) ^ ti);
    endfunction
    function automatic bit g_used(input int idx, input int v);
        return bit'(((idx >> 1) ^ v) & 1);
    endfunction
    function automatic bit g_gran(input int idx, input int v);
        return bit'((idx ^ (v >> 1)) & 1);
    endfunction

    task automatic put_desc(input int ti, input int idx, input int v);
        logic [23:0] b;
        logic [19:0] l;
        logic [31:0] hi;
        int w;
        b  = g_base(ti, idx, v);
        l  = g_lim(ti, idx, v);
        hi = {8'hA5, g_gran(idx, v), 3'b100, l[19:16], 7'b1001001, g_used(idx, v), b[23:16]};
        w  = ti * 32 + idx * 2;
        mem[w]     = {b[15:0], l[15:0]};
        mem[w + 1] = hi;
    endtask

    task automatic run_load(input logic [15:0] s, input bit extra, input logic [15:0] s2);
        log_n = 0;
        @(negedge clk);
        sel_wdata = s;
        sel_wr    = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0;
        chk(busy == 1'b1, "R7", "busy after write", 32'(busy), 32'd1);
        chk(cache_valid == 1'b0, "R7", "valid during load", 32'(cache_valid), 32'd0);
        if (extra) begin
            sel_wdata = s2;
            sel_wr    = 1'b1;
            @(negedge clk);
            sel_wr = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(cache_valid == 1'b1, "R7", "valid after load", 32'(cache_valid), 32'd1);
    endtask

    task automatic verify(input int ti, input int idx, input int rpl, input int v);
        logic [31:0] ea;
        logic [23:0] b;
        logic [19:0] l;
        logic [7:0]  acc;
        logic [31:0] el;
        bit          used;
        bit          g;
        ea   = (ti != 0 ? ldt_base : gdt_base) + 32'(idx * 8);
        b    = g_base(ti, idx, v);
        l    = g_lim(ti, idx, v);
        used = g_used(idx, v);
        g    = g_gran(idx, v);
        acc  = {7'b1001001, 1'b1};
        el   = g ? {l, 12'hFFF} : {12'h0, l};
        chk(sel_q == 16'(idx * 8 + ti * 4 + rpl), "R2", "sel_q", 32'(sel_q), 32'(idx * 8 + ti * 4 + rpl));
        chk(sel_index == 13'(idx) && sel_ti == 1'(ti) && sel_rpl == 2'(rpl), "R2", "fields",
            {sel_index, sel_ti, sel_rpl}, 32'(idx * 8 + ti * 4 + rpl));
        chk(log_n == (used ? 2 : 3), "R5", "access count", 32'(log_n), used ? 32'd2 : 32'd3);
        chk(log_addr[0] == ea && !log_we[0], "R3", "first read addr", log_addr[0], ea);
        chk(log_addr[1] == ea + 4 && !log_we[1], "R4", "second read addr", log_addr[1], ea + 4);
        if (!used) begin
            chk(log_addr[2] == ea + 4 && log_we[2], "R5", "writeback addr", log_addr[2], ea + 4);
            chk(mem[ea[7:2] + 1][8] == 1'b1, "R5", "used flag in memory", 32'(mem[ea[7:2] + 1][8]), 32'd1);
        end
        chk(cached_base == b, "R6", "base", 32'(cached_base), 32'(b));
        chk(cached_limit == l, "R6", "limit", 32'(cached_limit), 32'(l));
        chk(cached_gran == g, "R6", "gran", 32'(cached_gran), 32'(g));
        chk(cached_access == acc, "R6", "access", 32'(cached_access), 32'(acc));
        chk(eff_limit == el, "R9", "eff_limit", eff_limit, el);
        ref_off = 24'(24'h001357 + idx * 24'h010203);
        #1;
        chk(lin_addr == 24'(b + ref_off), "R9", "lin_addr", 32'(lin_addr), 32'(24'(b + ref_off)));
    endtask

    initial begin
        rst       = 1'b1;
        sel_wr    = 1'b0;
        sel_wdata = '0;
        gdt_base  = 32'h0000_0000;
        ldt_base  = 32'h0000_0080;
        ref_off   = '0;
        mem_rdata = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !cache_valid && !mem_req, "R1", "control low", {29'd0, busy, cache_valid, mem_req}, 32'd0);
        chk(sel_q == 16'd0 && cached_base == 24'd0 && cached_limit == 20'd0 && cached_access == 8'd0,
            "R1", "fields zero", {sel_q, cached_access, 8'd0}, 32'd0);

        // sweep: both tables, all 16 entries, varied latency and used flag
        for (int ti = 0; ti < 2; ti++) begin
            for (int idx = 0; idx < 16; idx++) begin
                int v;
                int rpl;
                v   = (ti * 16 + idx) % 4;
                rpl = (idx + ti) % 4;
                lat = idx % 3;
                put_desc(ti, idx, v);
                run_load(16'(idx * 8 + ti * 4 + rpl), 1'b0, 16'h0);
                verify(ti, idx, rpl, v);
            end
        end

        // R8: a write during the load is ignored
        lat = 1;
        put_desc(0, 7, 2);
        run_load(16'(7 * 8 + 1), 1'b1, 16'(12 * 8 + 4 + 3));
        verify(0, 7, 1, 2);

        // R10: memory edit not seen until reload
        put_desc(1, 9, 3);
        run_load(16'(9 * 8 + 4 + 2), 1'b0, 16'h0);
        verify(1, 9, 2, 3);
        put_desc(1, 9, 1);
        repeat (5) @(negedge clk);
        ref_off = 24'h000100;
        #1;
        chk(cached_base == g_base(1, 9, 3), "R10", "base held after edit", 32'(cached_base), 32'(g_base(1, 9, 3)));
        chk(cached_limit == g_lim(1, 9, 3), "R10", "limit held after edit", 32'(cached_limit), 32'(g_lim(1, 9, 3)));
        chk(lin_addr == 24'(g_base(1, 9, 3) + 24'h000100), "R10", "lin_addr held",
            32'(lin_addr), 32'(24'(g_base(1, 9, 3) + 24'h000100)));
        run_load(16'(9 * 8 + 4 + 2), 1'b0, 16'h0);
        verify(1, 9, 2, 1);

        // R3: moved table base
        gdt_base = 32'h0000_0040;
        put_desc(1, 0, 2);
        run_load(16'(8 * 8 + 0), 1'b0, 16'h0);
        chk(log_addr[0] == 32'h0000_0080, "R3", "moved base addr", log_addr[0], 32'h0000_0080);

        repeat (4) @(negedge clk);
        chk(idle_req == 0, "R9", "idle requests", 32'(idle_req), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule